// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital side of a dual-slope integrating analog-to-digital converter. It controls an external integrator front end over three wires: two phase-select outputs that it drives, and one zero-crossing comparator input that it reads. Between conversions it parks the front end in auto-zero. A start pulse launches one conversion, which runs four phases in a fixed order: auto-zero, signal integrate, reference de-integrate and integrator zero. The lengths of auto-zero and signal integrate are parameters counted in clock cycles.

While the front end de-integrates, an internal counter measures the time until the comparator falls. That count is the magnitude of the result. The comparator level, sampled in the last integrate cycle, gives the sign. If the comparator never falls, the de-integrate phase stops at twice the integrate length and the result is flagged as overrange. The integrator-zero phase ends as soon as the comparator reads high again. If the comparator never reads high, a timeout of one integrate length ends the phase and raises an error flag.

The result comes out as a sign bit, a magnitude, an overrange flag and an error flag. These are qualified by a single-cycle done pulse and held until the next accepted start. The result is held, so the output side needs no back-pressure: a consumer may read it at any time before it issues the next start. Start, busy and done are plain control pins.

Top module: `dsq_top`

## Requirements
- R1: After reset, the phase-select pair {phase_a_o, phase_b_o} is 01, busy_o and done_o are 0, and sign_o, mag_o, ovr_o and zerr_o are all 0.
- R2: While idle, the phase pair stays at 01 (auto-zero) until start_i is seen. A start_i pulse while busy_o is 1 has no effect on the running conversion's phase lengths or results.
- R3: The phase pair uses this encoding: 00 = integrator zero, 01 = auto-zero, 10 = signal integrate, 11 = reference de-integrate. An accepted start gives exactly AZ_CYCLES cycles of 01 with busy_o high, then exactly INT_CYCLES cycles of 10, then 11, then 00, and then 01 again.
- R4: sign_o is the synchronized comparator level in the last signal-integrate cycle (1 = positive input, 0 = negative input). Comparator toggles earlier in integrate, and any comparator activity during auto-zero, do not affect it.
- R5: mag_o is the number of de-integrate cycles before the cycle in which the two-flop-synchronized comparator shows a high-to-low transition. The comparator is counted from the cycle the phase pair turns 11. If the raw input falls during de-integrate cycle D, mag_o = D+2 and the phase pair shows 11 for D+3 cycles.
- R6: If no falling edge is seen within 2*INT_CYCLES de-integrate cycles, the phase ends after exactly 2*INT_CYCLES cycles, ovr_o = 1 and mag_o = 2*INT_CYCLES. A fall seen in the last allowed cycle still gives ovr_o = 0.
- R7: Integrator zero (00) ends on the cycle after the synchronized comparator reads high, and the pair then returns to 01. If the raw input rises during integrator-zero cycle Z, the pair shows 00 for Z+3 cycles.
- R8: If the synchronized comparator does not read high within INT_CYCLES integrator-zero cycles, the phase ends after exactly INT_CYCLES cycles and zerr_o = 1. Otherwise zerr_o = 0.
- R9: done_o is high for exactly one cycle: the first cycle back at 01, in which busy_o is already 0. sign_o, mag_o, ovr_o and zerr_o hold their values until the next accepted start, which clears them to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, honoured only while idle |
| cmp_i | input | 1 | Raw zero-crossing comparator level from the front end |
| phase_a_o | output | 1 | Phase select, upper bit |
| phase_b_o | output | 1 | Phase select, lower bit |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle pulse when a result becomes valid |
| sign_o | output | 1 | Input polarity, 1 = positive |
| mag_o | output | MAG_W | De-integrate count, MAG_W = clog2(2*INT_CYCLES+1) |
| ovr_o | output | 1 | Overrange: de-integrate limit reached |
| zerr_o | output | 1 | Integrator-zero phase timed out |

## Verification
The bench builds the block with INT_CYCLES = 16 and AZ_CYCLES = 10. The two lengths differ, so a mix-up between them shows up as a wrong phase length, and the 32-cycle de-integrate limit and the 16-cycle integrator-zero timeout are both reached within a few dozen cycles. With these short phases, both sides of the overrange boundary (a fall seen in the last allowed cycle and no fall at all) and both sides of the integrator-zero timeout can be run as separate directed conversions. Noise on the comparator during auto-zero and early integrate, and a start pulse issued mid-conversion, are also exercised.

// File: rtl/dsq_pkg.sv
package dsq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_AZ,
    ST_INT,
    ST_DEINT,
    ST_IZ
  } dsq_state_t;

  // Phase-select code driven on {A, B}
  localparam logic [1:0] AB_IZ    = 2'b00;
  localparam logic [1:0] AB_AZ    = 2'b01;
  localparam logic [1:0] AB_INT   = 2'b10;
  localparam logic [1:0] AB_DEINT = 2'b11;

  function automatic int dsq_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dsq_sync.sv
module dsq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic lvl_o,
  output logic fall_o
);

  logic [STAGES-1:0] chain;
  logic              prev_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= 1'b0;
        else        chain[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= 1'b0;
        else        chain[g] <= chain[g-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain[STAGES-1];
  end

  assign lvl_o  = chain[STAGES-1];
  assign fall_o = prev_q & ~chain[STAGES-1];

endmodule

// File: rtl/dsq_ctrl.sv
module dsq_ctrl import dsq_pkg::*; #(
  parameter int INT_CYCLES = 1000,
  parameter int AZ_CYCLES  = INT_CYCLES,
  parameter int CNT_W      = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             cmp_lvl_i,
  input  logic             cmp_fall_i,
  output logic [1:0]       ab_o,
  output logic             busy_o,
  output logic             acc_o,
  output logic             smp_o,
  output logic             cap_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovr_o,
  output logic             fin_o,
  output logic             zto_o
);

  localparam int DEINT_MAX = 2 * INT_CYCLES;
  localparam int TMR_W     = $clog2(dsq_max(AZ_CYCLES, DEINT_MAX) + 1);

  dsq_state_t       st_q, st_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;

  logic az_last, int_last, de_last, iz_last;
  assign az_last  = (tmr_q == TMR_W'(AZ_CYCLES - 1));
  assign int_last = (tmr_q == TMR_W'(INT_CYCLES - 1));
  assign de_last  = (tmr_q == TMR_W'(DEINT_MAX - 1));
  assign iz_last  = int_last;

  always_comb begin
    st_d  = st_q;
    tmr_d = tmr_q + TMR_W'(1);
    acc_o = 1'b0;
    smp_o = 1'b0;
    cap_o = 1'b0;
    ovr_o = 1'b0;
    fin_o = 1'b0;
    zto_o = 1'b0;
    cnt_o = CNT_W'(tmr_q);
    unique case (st_q)
      ST_IDLE: begin
        tmr_d = '0;
        if (start_i) begin
          acc_o = 1'b1;
          st_d  = ST_AZ;
        end
      end
      ST_AZ: begin
        if (az_last) begin
          st_d  = ST_INT;
          tmr_d = '0;
        end
      end
      ST_INT: begin
        if (int_last) begin
          smp_o = 1'b1;
          st_d  = ST_DEINT;
          tmr_d = '0;
        end
      end
      ST_DEINT: begin
        if (cmp_fall_i) begin
          cap_o = 1'b1;
          st_d  = ST_IZ;
          tmr_d = '0;
        end else if (de_last) begin
          cap_o = 1'b1;
          ovr_o = 1'b1;
          cnt_o = CNT_W'(DEINT_MAX);
          st_d  = ST_IZ;
          tmr_d = '0;
        end
      end
      ST_IZ: begin
        if (cmp_lvl_i) begin
          fin_o = 1'b1;
          st_d  = ST_IDLE;
          tmr_d = '0;
        end else if (iz_last) begin
          fin_o = 1'b1;
          zto_o = 1'b1;
          st_d  = ST_IDLE;
          tmr_d = '0;
        end
      end
      default: begin
        st_d  = ST_IDLE;
        tmr_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      tmr_q <= '0;
    end else begin
      st_q  <= st_d;
      tmr_q <= tmr_d;
    end
  end

  always_comb begin
    unique case (st_q)
      ST_INT:   ab_o = AB_INT;
      ST_DEINT: ab_o = AB_DEINT;
      ST_IZ:    ab_o = AB_IZ;
      default:  ab_o = AB_AZ;
    endcase
  end

  assign busy_o = (st_q != ST_IDLE);

  AST_IDLE_AB: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> ab_o == AB_AZ); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && !start_i) |=> !busy_o); // R2
  AST_INT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (ab_o == AB_INT) |=> (ab_o == AB_INT || ab_o == AB_DEINT)); // R3
  AST_DEINT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (ab_o == AB_DEINT) |=> (ab_o == AB_DEINT || ab_o == AB_IZ)); // R3
  AST_IZ_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (ab_o == AB_IZ) |=> (ab_o == AB_IZ || ab_o == AB_AZ)); // R3
  AST_DEINT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DEINT) |-> tmr_q < TMR_W'(DEINT_MAX)); // R6
  AST_IZ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IZ && cmp_lvl_i) |=> (ab_o == AB_AZ && !busy_o)); // R7

endmodule

// File: rtl/dsq_result.sv
module dsq_result #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             smp_i,
  input  logic             cmp_lvl_i,
  input  logic             cap_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             ovr_i,
  input  logic             fin_i,
  input  logic             zto_i,
  output logic             done_o,
  output logic             sign_o,
  output logic [CNT_W-1:0] mag_o,
  output logic             ovr_o,
  output logic             zerr_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o <= 1'b0;
      sign_o <= 1'b0;
      mag_o  <= '0;
      ovr_o  <= 1'b0;
      zerr_o <= 1'b0;
    end else begin
      done_o <= fin_i;
      if (clr_i) begin
        sign_o <= 1'b0;
        mag_o  <= '0;
        ovr_o  <= 1'b0;
        zerr_o <= 1'b0;
      end else begin
        if (smp_i) sign_o <= cmp_lvl_i;
        if (cap_i) begin
          mag_o <= cnt_i;
          ovr_o <= ovr_i;
        end
        if (fin_i) zerr_o <= zto_i;
      end
    end
  end

  AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R9
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !smp_i && !cap_i && !fin_i) |=>
      ($stable(mag_o) && $stable(sign_o) && $stable(ovr_o) && $stable(zerr_o))); // R9

endmodule

// File: rtl/dsq_top.sv
module dsq_top #(
  parameter int INT_CYCLES = 1000,
  parameter int AZ_CYCLES  = INT_CYCLES,
  localparam int MAG_W     = $clog2(2 * INT_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             cmp_i,
  output logic             phase_a_o,
  output logic             phase_b_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             sign_o,
  output logic [MAG_W-1:0] mag_o,
  output logic             ovr_o,
  output logic             zerr_o
);

  logic             cmp_lvl, cmp_fall;
  logic [1:0]       ab;
  logic             acc, smp, cap, ovr_ev, fin, zto;
  logic [MAG_W-1:0] cnt;

  dsq_sync #(.STAGES(2)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_i    (cmp_i),
    .lvl_o  (cmp_lvl),
    .fall_o (cmp_fall)
  );

  dsq_ctrl #(
    .INT_CYCLES (INT_CYCLES),
    .AZ_CYCLES  (AZ_CYCLES),
    .CNT_W      (MAG_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .cmp_lvl_i  (cmp_lvl),
    .cmp_fall_i (cmp_fall),
    .ab_o       (ab),
    .busy_o     (busy_o),
    .acc_o      (acc),
    .smp_o      (smp),
    .cap_o      (cap),
    .cnt_o      (cnt),
    .ovr_o      (ovr_ev),
    .fin_o      (fin),
    .zto_o      (zto)
  );

  dsq_result #(.CNT_W(MAG_W)) u_res (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (acc),
    .smp_i     (smp),
    .cmp_lvl_i (cmp_lvl),
    .cap_i     (cap),
    .cnt_i     (cnt),
    .ovr_i     (ovr_ev),
    .fin_i     (fin),
    .zto_i     (zto),
    .done_o    (done_o),
    .sign_o    (sign_o),
    .mag_o     (mag_o),
    .ovr_o     (ovr_o),
    .zerr_o    (zerr_o)
  );

  assign phase_a_o = ab[1];
  assign phase_b_o = ab[0];

endmodule

// File: tb/sim_dsq_top.sv
module sim_dsq_top;

  localparam int CLK_T = 10;
  localparam int TINT  = 16;
  localparam int TAZ   = 10;
  localparam int TMAX  = 2 * TINT;
  localparam int MW    = $clog2(TMAX + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          cmp = 1'b1;
  logic          pa, pb, busy, done, sign, ovr, zerr;
  logic [MW-1:0] mag;

  int total = 0;
  int bad   = 0;

  int n_az, n_int, n_de, n_iz;
  int got_done, done_after;

  dsq_top #(.INT_CYCLES(TINT), .AZ_CYCLES(TAZ)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start),
    .cmp_i     (cmp),
    .phase_a_o (pa),
    .phase_b_o (pb),
    .busy_o    (busy),
    .done_o    (done),
    .sign_o    (sign),
    .mag_o     (mag),
    .ovr_o     (ovr),
    .zerr_o    (zerr)
  );

  always #(CLK_T / 2) clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Drives one conversion and records phase lengths as seen at negedges.
  task automatic run_conv(input bit pos, input int d, input int z, input bit poke);
    int guard = 0;
    n_az = 0; n_int = 0; n_de = 0; n_iz = 0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy && guard < 2000) begin
      guard++;
      start = 1'b0;
      case ({pa, pb})
        2'b01: begin
          cmp = n_az[0];  // undefined comparator during auto-zero
          n_az++;
        end
        2'b10: begin
          if (n_int == 0 || n_int == 2) cmp = ~pos;
          else cmp = pos;
          if (poke && n_int == 3) start = 1'b1;
          n_int++;
        end
        2'b11: begin
          if (n_de == 0 && !pos) cmp = 1'b1;
          if (n_de == d) cmp = 1'b0;
          n_de++;
        end
        default: begin
          if (n_iz == z) cmp = 1'b1;
          n_iz++;
        end
      endcase
      @(negedge clk);
    end
    start = 1'b0;
    got_done = int'(done);
    @(negedge clk);
    done_after = int'(done);
  endtask

  task automatic expect_conv(input string tag, input bit pos, input int d, input int z);
    bit eo;
    int em, ede, eiz, ez;
    eo  = (d + 2 >= TMAX);
    em  = eo ? TMAX : d + 2;
    ede = eo ? TMAX : d + 3;
    if (eo)                eiz = 1;
    else if (z + 2 < TINT) eiz = z + 3;
    else                   eiz = TINT;
    ez  = (!eo && z + 2 >= TINT) ? 1 : 0;
    chk("R3", {tag, " auto-zero length"}, n_az, TAZ);
    chk("R3", {tag, " integrate length"}, n_int, TINT);
    chk("R4", {tag, " sign"}, int'(sign), int'(pos));
    chk("R5", {tag, " de-integrate length"}, n_de, ede);
    chk("R5", {tag, " magnitude"}, int'(mag), em);
    chk("R6", {tag, " overrange"}, int'(ovr), int'(eo));
    chk("R7", {tag, " integrator-zero length"}, n_iz, eiz);
    chk("R8", {tag, " zero error"}, int'(zerr), ez);
    chk("R9", {tag, " done at end"}, got_done, 1);
    chk("R9", {tag, " done one cycle"}, done_after, 0);
    chk("R9", {tag, " busy low at end"}, int'(busy), 0);
  endtask

  task automatic t_reset;
    chk("R1", "ab after reset", int'({pa, pb}), 1);
    chk("R1", "busy after reset", int'(busy), 0);
    chk("R1", "done after reset", int'(done), 0);
    chk("R1", "outputs after reset", int'({sign, ovr, zerr}) + int'(mag), 0);
    repeat (5) @(negedge clk);
    chk("R2", "idle holds auto-zero", int'({pa, pb}), 1);
    chk("R2", "idle not busy", int'(busy), 0);
  endtask

  task automatic t_positive;
    run_conv(1'b1, 7, 1, 1'b0);
    expect_conv("positive", 1'b1, 7, 1);
  endtask

  task automatic t_negative_poke;
    run_conv(1'b0, 5, 4, 1'b1);  // start pulse mid-conversion: R2
    expect_conv("negative+restart", 1'b0, 5, 4);
  endtask

  task automatic t_overrange;
    run_conv(1'b1, 100, 0, 1'b0);
    expect_conv("overrange", 1'b1, 100, 0);
  endtask

  task automatic t_last_count;
    run_conv(1'b1, TMAX - 3, 0, 1'b0);  // fall in last allowed cycle: R6
    expect_conv("last count", 1'b1, TMAX - 3, 0);
  endtask

  task automatic t_iz_edge;
    run_conv(1'b1, 2, TINT - 3, 1'b0);  // high in last integrator-zero cycle: R7
    expect_conv("iz last cycle", 1'b1, 2, TINT - 3);
  endtask

  task automatic t_iz_timeout;
    run_conv(1'b1, 3, 100, 1'b0);
    expect_conv("iz timeout", 1'b1, 3, 100);
    cmp = 1'b1;
  endtask

  task automatic t_hold_clear;
    run_conv(1'b0, 4, 0, 1'b0);
    repeat (6) begin
      cmp = ~cmp;
      @(negedge clk);
    end
    chk("R9", "magnitude held", int'(mag), 6);
    chk("R9", "sign held", int'(sign), 0);
    chk("R2", "idle ab while comparator toggles", int'({pa, pb}), 1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9", "magnitude cleared on start", int'(mag), 0);
    chk("R2", "busy after start", int'(busy), 1);
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_T * 150000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_positive();
    t_negative_poke();
    t_overrange();
    t_last_count();
    t_iz_edge();
    t_iz_timeout();
    t_hold_clear();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule